// File: doc/BRIEF.md
# Serial Line Receiver with Overhead-Bit Framing, Block Check and Descrambling

This block terminates one serial line. The raw line level is brought into the local clock domain and sampled on an oversampling enable. A single bit is recovered near the centre of each bit cell, and the phase of the sampling is pulled back into line on every transition. The recovered bits are grouped into frames of sixteen. The last bit of every frame is a balance bit that the far end sets to the complement of the payload bit just before it. The receiver uses these bits to find the frame alignment, hold it and drop it. Balance bits are consumed and never passed on.

Once in sync, each payload bit goes to two places. The first is a CRC-16 check run over fixed-length blocks of line payload bits. The second is an XOR with a key stream from a 23-bit LFSR, which gives the clear-text output. That output is a single-cycle valid pulse with a data bit. The key generator is reloaded from a fixed seed at the moment sync is gained. The block-check count restarts at the same moment. When alignment is lost, the receiver hunts again bit by bit without outside help.

Top module: `serial_link_rx`

## Requirements
- R1: While reset is held and straight after it, `in_sync`, `out_valid`, `blk_end` and `crc_err` are all 0.
- R2: When in sync, frame positions 0..FRAME_LEN-2 are payload, and each payload bit produces exactly one `out_valid` pulse. Pulses come in line order. The balance bit at position FRAME_LEN-1 never produces a pulse, and no pulse is given while out of sync.
- R3: `out_bit` is the line payload bit XOR key bit. The key bit is bit 22 of a 23-bit state. The state is loaded with SEED when sync is gained and moves on only after each payload bit, to {s[21:0], s[22]^s[17]}.
- R4: When out of sync, a bit counts as a good balance candidate if it differs from the bit received just before it. A bad candidate moves the trial position on by one bit. A good candidate moves it on by FRAME_LEN bits. After SYNC_HITS good candidates in a row, `in_sync` rises, and the next bit is position 0.
- R5: When in sync, a balance bit equal to the bit before it is a miss, and a good balance bit clears the miss count. Fewer than LOSS_MISSES misses in a row leave sync in place. The LOSS_MISSES-th miss in a row drops `in_sync`, and the hunt then starts with the very next bit.
- R6: From the moment sync is gained, payload bits are counted in blocks of BLOCK_BITS. Each block runs a CRC (polynomial 0x1021, preset 0xFFFF, MSB-first shift, line bits before descrambling). `blk_end` pulses together with the `out_valid` of the last bit of a block. `crc_err` is high in that same cycle exactly when the final remainder is not zero.
- R7: On `sample_en` pulses, one bit is recovered per OVS pulses, from the samples near the cell centre. A transition restarts the cell phase, so a cell lengthened by up to three pulses still yields exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Oversampling enable, OVS pulses per line bit |
| line_in | input | 1 | Raw line level, asynchronous to clk |
| out_valid | output | 1 | One-cycle pulse per forwarded clear-text bit |
| out_bit | output | 1 | Clear-text bit, qualified by out_valid |
| in_sync | output | 1 | Frame alignment held |
| blk_end | output | 1 | Last payload bit of a check block is on the output |
| crc_err | output | 1 | Block remainder non-zero, qualified by blk_end |

## Verification
The bench builds the receiver with OVS=4 and BLOCK_BITS=64, keeping FRAME_LEN=16, SYNC_HITS=8, LOSS_MISSES=4 and the default seed. Four samples per bit give a short run per bit, and 64-bit blocks give many full blocks per lock. Together they let one run cover several relocks, a bit slip, a three-miss burst that must be tolerated, a four-miss burst that must drop sync, and a deliberately broken block. Lengthened cells exercise phase realignment with the short cell.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

  typedef enum logic {
    HUNT = 1'b0,
    LOCK = 1'b1
  } sync_state_e;

  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  // one MSB-first CRC shift for a single incoming bit
  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  // 23-bit key generator step, taps 23 and 18
  function automatic logic [22:0] key_next(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_restrobe.sv
module rx_restrobe #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic line_in,
  output logic bit_stb,
  output logic bit_val
);
  import rxl_pkg::*;

  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_VOTE = PW'(OVS / 2 + 1);

  logic          sy1, sy2, sy_prev;
  logic [1:0]    hist;
  logic [PW-1:0] phase;
  logic          edge_seen;
  logic          vote_now;

  assign edge_seen = sample_en && (sy2 != sy_prev);
  assign vote_now  = sample_en && !edge_seen && (phase == PH_VOTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
    end else begin
      sy1 <= line_in;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_prev <= 1'b0;
      hist    <= '0;
      phase   <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (sample_en) begin
        sy_prev <= sy2;
        hist    <= {hist[0], sy2};
        if (edge_seen)             phase <= PW'(1);
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + PW'(1);
        if (vote_now) begin
          bit_stb <= 1'b1;
          bit_val <= vote3(hist[1], hist[0], sy2);
        end
      end
    end
  end

endmodule

// File: rtl/rx_framer.sv
module rx_framer #(
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_HITS   = 8,
  parameter int LOSS_MISSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  output logic pay_stb,
  output logic pay_bit,
  output logic frame_start,
  output logic sync_lost,
  output logic in_sync
);
  import rxl_pkg::*;

  localparam int PW = $clog2(FRAME_LEN);
  localparam int HW = $clog2(SYNC_HITS + 1);
  localparam int MW = $clog2(LOSS_MISSES + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_LEN - 1);
  localparam logic [HW-1:0] HIT_LAST = HW'(SYNC_HITS - 1);
  localparam logic [MW-1:0] MIS_LAST = MW'(LOSS_MISSES - 1);

  sync_state_e   st;
  logic [PW-1:0] pos;
  logic [HW-1:0] hits;
  logic [MW-1:0] miss;
  logic          prev_bit;
  logic          at_ovh, ovh_ok;

  assign at_ovh      = bit_stb && (pos == POS_LAST);
  assign ovh_ok      = (bit_val != prev_bit);
  assign pay_stb     = bit_stb && (st == LOCK) && (pos != POS_LAST);
  assign pay_bit     = bit_val;
  assign frame_start = at_ovh && (st == HUNT) && ovh_ok && (hits == HIT_LAST);
  assign sync_lost   = at_ovh && (st == LOCK) && !ovh_ok && (miss == MIS_LAST);
  assign in_sync     = (st == LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HUNT;
      pos      <= POS_LAST;
      hits     <= '0;
      miss     <= '0;
      prev_bit <= 1'b0;
    end else if (bit_stb) begin
      prev_bit <= bit_val;
      if (!at_ovh) begin
        pos <= pos + PW'(1);
      end else if (st == HUNT) begin
        if (ovh_ok) begin
          pos <= '0;
          if (frame_start) begin
            st   <= LOCK;
            hits <= '0;
            miss <= '0;
          end else begin
            hits <= hits + HW'(1);
          end
        end else begin
          hits <= '0;          // slip by one bit: test the next bit
        end
      end else begin
        if (ovh_ok) begin
          miss <= '0;
          pos  <= '0;
        end else if (sync_lost) begin
          st   <= HUNT;
          miss <= '0;
          hits <= '0;
          pos  <= POS_LAST;
        end else begin
          miss <= miss + MW'(1);
          pos  <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/rx_descrambler.sv
module rx_descrambler #(
  parameter logic [22:0] SEED = 23'h5A5A5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pay_stb,
  input  logic pay_bit,
  output logic out_valid,
  output logic out_bit
);
  import rxl_pkg::*;

  logic [22:0] key_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st    <= SEED;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= pay_stb;
      if (frame_start) begin
        key_st <= SEED;
      end else if (pay_stb) begin
        out_bit <= pay_bit ^ key_st[22];
        key_st  <= key_next(key_st);
      end
    end
  end

endmodule

// File: rtl/rx_blockcheck.sv
module rx_blockcheck #(
  parameter int BLOCK_BITS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pay_stb,
  input  logic pay_bit,
  output logic blk_end,
  output logic crc_err
);
  import rxl_pkg::*;

  localparam int CW = $clog2(BLOCK_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(BLOCK_BITS - 1);

  logic [15:0]   crc_q, crc_d;
  logic [CW-1:0] cnt;

  assign crc_d = crc16_next(crc_q, pay_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= CRC_PRESET;
      cnt     <= '0;
      blk_end <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      blk_end <= 1'b0;
      crc_err <= 1'b0;
      if (frame_start) begin
        crc_q <= CRC_PRESET;
        cnt   <= '0;
      end else if (pay_stb) begin
        if (cnt == CNT_LAST) begin
          blk_end <= 1'b1;
          crc_err <= (crc_d != 16'h0000);
          crc_q   <= CRC_PRESET;
          cnt     <= '0;
        end else begin
          crc_q <= crc_d;
          cnt   <= cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/serial_link_rx.sv
module serial_link_rx #(
  parameter int          OVS         = 16,
  parameter int          FRAME_LEN   = 16,
  parameter int          SYNC_HITS   = 8,
  parameter int          LOSS_MISSES = 4,
  parameter int          BLOCK_BITS  = 1024,
  parameter logic [22:0] SEED        = 23'h5A5A5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic line_in,
  output logic out_valid,
  output logic out_bit,
  output logic in_sync,
  output logic blk_end,
  output logic crc_err
);

  // internal events, named for the checker
  logic bit_stb, bit_val;
  logic pay_stb, pay_bit;
  logic frame_start, sync_lost;

  rx_restrobe #(.OVS(OVS)) u_restrobe (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .line_in(line_in),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  rx_framer #(
    .FRAME_LEN(FRAME_LEN), .SYNC_HITS(SYNC_HITS), .LOSS_MISSES(LOSS_MISSES)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .pay_stb(pay_stb), .pay_bit(pay_bit), .frame_start(frame_start),
    .sync_lost(sync_lost), .in_sync(in_sync)
  );

  rx_descrambler #(.SEED(SEED)) u_descr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pay_stb(pay_stb), .pay_bit(pay_bit),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  rx_blockcheck #(.BLOCK_BITS(BLOCK_BITS)) u_blk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pay_stb(pay_stb), .pay_bit(pay_bit),
    .blk_end(blk_end), .crc_err(crc_err)
  );

endmodule

// File: rtl/serial_link_rx_chk.sv
module serial_link_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic pay_stb,
  input logic frame_start,
  input logic sync_lost,
  input logic in_sync,
  input logic out_valid,
  input logic blk_end,
  input logic crc_err
);

  p_pay_only_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pay_stb |-> in_sync);

  p_valid_follows_pay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pay_stb |=> out_valid);

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_lock_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> in_sync);

  p_lock_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(frame_start));

  p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> $past(sync_lost));

  p_blk_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> out_valid);

  p_err_in_blk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> blk_end);

  p_bit_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

endmodule

bind serial_link_rx serial_link_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pay_stb(pay_stb),
  .frame_start(frame_start), .sync_lost(sync_lost), .in_sync(in_sync),
  .out_valid(out_valid), .blk_end(blk_end), .crc_err(crc_err)
);

// File: tb/serial_link_rx_tb.sv
module serial_link_rx_tb;

  localparam int          OVS   = 4;
  localparam int          BLK   = 64;
  localparam logic [22:0] SEED  = 23'h5A5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic line_in = 1'b0;
  logic out_valid, out_bit, in_sync, blk_end, crc_err;

  always #10 clk = ~clk;

  serial_link_rx #(.OVS(OVS), .BLOCK_BITS(BLK), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .line_in(line_in),
    .out_valid(out_valid), .out_bit(out_bit), .in_sync(in_sync),
    .blk_end(blk_end), .crc_err(crc_err)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model (integer based) ----------------
  bit exp_out[$];
  bit exp_sync[$];
  bit exp_crc[$];
  int m_locked = 0, m_pos = 15, m_prev = 0, m_hits = 0, m_miss = 0;
  int m_key[23];
  int m_crc = 'hFFFF;
  int m_cnt = 0;
  int n_rise = 0, n_fall = 0, n_bad_blk = 0, n_good_blk = 0;

  task automatic model_bit(input int b);
    if (m_pos == 15) begin
      if (!m_locked) begin
        if (b != m_prev) begin
          m_hits++; m_pos = 0;
          if (m_hits == 8) begin
            m_locked = 1; m_miss = 0; m_hits = 0;
            exp_sync.push_back(1'b1); n_rise++;
            for (int i = 0; i < 23; i++) m_key[i] = int'(SEED[i]);
            m_crc = 'hFFFF; m_cnt = 0;
          end
        end else m_hits = 0;
      end else begin
        if (b != m_prev) begin m_miss = 0; m_pos = 0; end
        else begin
          m_miss++;
          if (m_miss == 4) begin
            m_locked = 0; m_hits = 0; m_miss = 0; m_pos = 15;
            exp_sync.push_back(1'b0); n_fall++;
          end else m_pos = 0;
        end
      end
    end else begin
      if (m_locked) begin
        int fb, nk;
        exp_out.push_back(bit'(b ^ m_key[22]));
        nk = m_key[22] ^ m_key[17];
        for (int i = 22; i > 0; i--) m_key[i] = m_key[i-1];
        m_key[0] = nk;
        fb = ((m_crc >> 15) & 1) ^ b;
        m_crc = (m_crc * 2) % 65536;
        if (fb != 0) m_crc = m_crc ^ 'h1021;
        m_cnt++;
        if (m_cnt == BLK) begin
          exp_crc.push_back(bit'(m_crc != 0));
          if (m_crc != 0) n_bad_blk++; else n_good_blk++;
          m_crc = 'hFFFF; m_cnt = 0;
        end
      end
      m_pos++;
    end
    m_prev = b;
  endtask

  // ---------------- line driver ----------------
  int pend = -1;
  int n_stretch = 0;

  task automatic drive(input int b, input int extra);
    line_in = b[0];
    sample_en = 1'b1;
    repeat (OVS + extra) @(negedge clk);
  endtask

  task automatic emit(input int b);
    model_bit(b);
    if (pend >= 0) begin
      int ex = 0;
      if (b != pend && ($urandom % 4) == 0) begin ex = 1 + ($urandom % 3); n_stretch++; end
      drive(pend, ex);
    end
    pend = b;
  endtask

  // ---------------- transmitter ----------------
  int tx_last = 0;
  int bad_ovh = 0;
  int bad_crc = 0;

  task automatic gen_frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int p = 0; p < 16; p++) begin
        int b;
        if (p == 15) begin
          b = tx_last ^ 1;
          if (bad_ovh > 0) begin b = tx_last; bad_ovh--; end
        end else begin
          if (m_locked != 0 && m_pos != 15 && m_cnt >= BLK - 16) begin
            b = (m_crc >> 15) & 1;
            if (bad_crc != 0 && m_cnt == BLK - 1) begin b = b ^ 1; bad_crc = 0; end
          end else b = int'($urandom % 2);
          tx_last = b;
        end
        emit(b);
      end
    end
  endtask

  // ---------------- monitor ----------------
  bit mon_on = 0;
  bit last_sync = 0;
  int seen_rise = 0, seen_fall = 0, seen_bad = 0, seen_out = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        seen_out++;
        if (exp_out.size() == 0) chk(1'b0, "R2 unexpected out_valid", 1, 0);
        else begin
          bit e;
          e = exp_out.pop_front();
          chk(out_bit == e, "R3 R7 out_bit", int'(out_bit), int'(e));
        end
      end
      if (blk_end) begin
        if (exp_crc.size() == 0) chk(1'b0, "R6 unexpected blk_end", 1, 0);
        else begin
          bit e;
          e = exp_crc.pop_front();
          if (crc_err) seen_bad++;
          chk(crc_err == e, "R6 crc_err", int'(crc_err), int'(e));
        end
      end else if (crc_err) chk(1'b0, "R6 crc_err without blk_end", 1, 0);
      if (in_sync != last_sync) begin
        if (in_sync) seen_rise++; else seen_fall++;
        if (exp_sync.size() == 0) chk(1'b0, "R4 R5 unexpected sync change", int'(in_sync), int'(last_sync));
        else begin
          bit e;
          e = exp_sync.pop_front();
          chk(in_sync == e, e ? "R4 lock" : "R5 loss", int'(in_sync), int'(e));
        end
        last_sync = in_sync;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R2 got=hang exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(in_sync == 1'b0,   "R1 in_sync in reset",   int'(in_sync), 0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(blk_end == 1'b0,   "R1 blk_end after reset", int'(blk_end), 0);
    chk(crc_err == 1'b0,   "R1 crc_err after reset", int'(crc_err), 0);
    chk(in_sync == 1'b0,   "R1 in_sync after reset", int'(in_sync), 0);
    mon_on = 1;

    // leading 1 gives the first transition, then some unframed bits
    emit(1);
    for (int i = 0; i < 5; i++) emit(int'($urandom % 2));
    gen_frames(30);                     // R4 lock, R6 good blocks
    bad_ovh = 3; gen_frames(10);        // R5 three misses tolerated
    bad_crc = 1; gen_frames(10);        // R6 corrupted block
    bad_ovh = 4; gen_frames(30);        // R5 loss, R4 relock
    emit(int'($urandom % 2));           // bit slip
    gen_frames(40);
    // flush last bit, then stop sampling
    drive(pend, 0);
    sample_en = 1'b0;
    repeat (12) @(negedge clk);
    mon_on = 0;

    chk(exp_out.size() == 0,  "R2 missing out bits", exp_out.size(), 0);
    chk(exp_crc.size() == 0,  "R6 missing blocks", exp_crc.size(), 0);
    chk(exp_sync.size() == 0, "R4 R5 missing sync changes", exp_sync.size(), 0);
    chk(seen_rise == n_rise && n_rise >= 2, "R4 lock count", seen_rise, n_rise);
    chk(seen_fall == n_fall && n_fall >= 1, "R5 loss count", seen_fall, n_fall);
    chk(seen_bad == n_bad_blk && n_bad_blk >= 1 && n_good_blk >= 3, "R6 bad block count", seen_bad, n_bad_blk);
    chk(n_stretch > 0 && seen_out > 1000, "R7 stretched cells exercised", n_stretch, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule